// File: doc/BRIEF.md
# Parallel Bus Target Handshake Controller

This block is the target end of an 8-bit parallel peripheral bus. A host picks one target by pulling the select line low together with a single data line; line n picks unit n. When that line is the block's own unit number and the block is free, it pulls busy low. It then waits for select to go high, so the selecting data line is never read as a command byte. After that it runs the whole transaction, using one request/acknowledge handshake for each byte. All bus signals are active-low.

A transaction runs in a fixed order: a set number of command bytes, a data phase, one status byte, one message byte, then bus release. After the command bytes, the local logic supplies the data-phase length, its direction, the status byte and the message byte through a valid/ready setup port. Bytes from the host leave through a valid/ready receive port, which is tagged command or data. Bytes for the host enter through a valid/ready transmit port. A low on the host reset line returns the block to idle from any state.

Top module: `pbus_target`

## Requirements
- R1: During and after the synchronous reset `rst`, bsy_n, req_n, io_n, cd_n and msg_n are high, db_oe is 0 and rx_valid is 0.
- R2: busy falls one cycle after a clock edge that samples all three of: sel_n low, exactly one data line low, and that line's index equal to UNIT_ID. No other select pattern produces a response: a different unit's line, two or more lines low, or no line low.
- R3: req_n stays high while sel_n is low. The first command REQ comes only after the host has released sel_n.
- R4: The command phase moves exactly CMD_BYTES bytes from host to target with io_n=1, cd_n=0 and msg_n=1. Each byte appears on rx_data as the inverse of the bus lines, with rx_is_cmd=1.
- R5: REQ is asserted only while ACK is released. It is deasserted the cycle after ACK is seen low. It is not asserted again until ACK returns high. Exactly one byte moves per REQ.
- R6: For a byte sent to the host, db_oe is 1 and db_out_n carries the inverted byte before REQ falls. Both stay unchanged until REQ rises.
- R7: The data phase moves cfg_len bytes. It uses cd_n=1, with io_n=0 when cfg_to_host=1 and io_n=1 otherwise. Host bytes appear on rx with rx_is_cmd=0. Bytes for the host are taken from tx in order. A length of 0 goes straight to status.
- R8: After the data phase, the status byte is sent with io_n=0, cd_n=0, msg_n=1. The message byte follows with io_n=0, cd_n=0, msg_n=0. busy is released once the message handshake completes.
- R9: A low on bus_rst_n that is sampled at an edge puts the block in idle with all bus outputs high and db_oe=0 by the next cycle. A new selection then works normally.
- R10: A received byte holds rx_valid and rx_data until rx_ready. No further host-to-target REQ is issued while a byte is still waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rst_n | input | 1 | Host bus reset, active low |
| bus_sel_n | input | 1 | Host select, active low |
| bus_ack_n | input | 1 | Host acknowledge, active low |
| bus_db_in_n | input | 8 | Bus data lines as received, active low |
| bus_bsy_n | output | 1 | Busy, active low |
| bus_req_n | output | 1 | Byte request, active low |
| bus_io_n | output | 1 | Direction, low = target to host |
| bus_cd_n | output | 1 | Low = command/status/message, high = data |
| bus_msg_n | output | 1 | Message phase, active low |
| bus_db_out_n | output | 8 | Bus data driven by target, active low |
| bus_db_oe | output | 1 | Target drives data lines |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Local sink takes received byte |
| rx_data | output | 8 | Received byte |
| rx_is_cmd | output | 1 | Received byte came from command phase |
| tx_valid | input | 1 | Local source has a byte for host |
| tx_ready | output | 1 | Block takes tx_data this cycle |
| tx_data | input | 8 | Byte for host |
| cfg_valid | input | 1 | Setup values valid |
| cfg_ready | output | 1 | Setup accepted this cycle |
| cfg_len | input | LEN_W | Data-phase byte count |
| cfg_to_host | input | 1 | Data phase direction, 1 = to host |
| cfg_status | input | 8 | Status byte |
| cfg_msg | input | 8 | Message byte |

## Verification
The main flow is exercised with a table of transactions. The table varies data length (including zero), direction, status, message and command seeds. This separates direction decoding, length counting and correct phase-line settings in each phase. Directed cases present select patterns naming another unit, several lines low at once, and no line low. These show that only a clean one-hot match on the block's own line is accepted. Further cases stall the receive sink, to show that requests are held back, and pulse the host reset mid-command, to show a full release followed by a clean new transaction.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int BUS_W = 8;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SELREL,
        SQ_CMD,
        SQ_SETUP,
        SQ_DATA,
        SQ_STAT,
        SQ_MSG
    } seq_state_t;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_SETUP,
        HS_REQ,
        HS_REL
    } hs_state_t;

    // active-high meaning of the three phase lines
    typedef struct packed {
        logic to_host;
        logic is_data;
        logic is_msg;
    } phase_t;

    typedef struct packed {
        logic [BUS_W-1:0] len_dummy;
        logic             unused;
    } reserved_t;

    function automatic logic exactly_one(input logic [BUS_W-1:0] v);
        int n;
        n = 0;
        for (int i = 0; i < BUS_W; i++) begin
            if (v[i]) n++;
        end
        return (n == 1);
    endfunction

endpackage

// File: rtl/pbus_sel_det.sv
module pbus_sel_det
    import pbus_pkg::*;
#(
    parameter int UNIT_ID = 2
) (
    input  logic             sel_n,
    input  logic [BUS_W-1:0] db_n,
    output logic             hit
);
    logic [BUS_W-1:0] lines;

    always_comb begin
        lines = ~db_n;
        hit   = !sel_n && exactly_one(lines) && lines[UNIT_ID];
    end
endmodule

// File: rtl/pbus_byte_hs.sv
module pbus_byte_hs
    import pbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             start,
    input  logic             to_host,
    input  logic [BUS_W-1:0] byte_in,
    input  logic             ack_n,
    output logic             idle,
    output logic             req,
    output logic             oe,
    output logic [BUS_W-1:0] byte_out,
    output logic             cap,
    output logic             done
);
    hs_state_t        st;
    logic             dir_q;
    logic [BUS_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st    <= HS_IDLE;
            dir_q <= 1'b0;
            out_q <= '0;
        end else begin
            case (st)
                HS_IDLE: if (start) begin
                    dir_q <= to_host;
                    out_q <= byte_in;
                    st    <= HS_SETUP;
                end
                HS_SETUP: if (ack_n) st <= HS_REQ;
                HS_REQ:   if (!ack_n) st <= HS_REL;
                HS_REL:   if (ack_n) st <= HS_IDLE;
                default:  st <= HS_IDLE;
            endcase
        end
    end

    always_comb begin
        idle     = (st == HS_IDLE);
        req      = (st == HS_REQ);
        oe       = dir_q && (st != HS_IDLE);
        byte_out = out_q;
        cap      = (st == HS_REQ) && !ack_n && !dir_q;
        done     = (st == HS_REL) && ack_n;
    end
endmodule

// File: rtl/pbus_phase_seq.sv
module pbus_phase_seq
    import pbus_pkg::*;
#(
    parameter int CMD_BYTES = 6,
    parameter int LEN_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             sel_hit,
    input  logic             sel_n,
    input  logic             hs_idle,
    input  logic             hs_done,
    input  logic             rx_pend,
    input  logic             tx_valid,
    input  logic [BUS_W-1:0] tx_data,
    input  logic             cfg_valid,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_to_host,
    input  logic [BUS_W-1:0] cfg_status,
    input  logic [BUS_W-1:0] cfg_msg,
    output logic             busy,
    output phase_t           phase,
    output logic             in_cmd,
    output logic             hs_start,
    output logic             hs_to_host,
    output logic [BUS_W-1:0] hs_byte,
    output logic             tx_ready,
    output logic             cfg_ready
);
    localparam int CMD_W = $clog2(CMD_BYTES + 1);
    localparam int CW    = (LEN_W > CMD_W) ? LEN_W : CMD_W;

    seq_state_t       st;
    logic [CW-1:0]    cnt;
    logic [LEN_W-1:0] len_q;
    logic             dir_q;
    logic [BUS_W-1:0] stat_q;
    logic [BUS_W-1:0] msg_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st     <= SQ_IDLE;
            cnt    <= '0;
            len_q  <= '0;
            dir_q  <= 1'b0;
            stat_q <= '0;
            msg_q  <= '0;
        end else begin
            case (st)
                SQ_IDLE:   if (sel_hit) st <= SQ_SELREL;
                SQ_SELREL: if (sel_n) begin
                    st  <= SQ_CMD;
                    cnt <= '0;
                end
                SQ_CMD: if (hs_done) begin
                    if (cnt == CW'(CMD_BYTES - 1)) st <= SQ_SETUP;
                    else cnt <= cnt + 1'b1;
                end
                SQ_SETUP: if (cfg_valid) begin
                    len_q  <= cfg_len;
                    dir_q  <= cfg_to_host;
                    stat_q <= cfg_status;
                    msg_q  <= cfg_msg;
                    cnt    <= '0;
                    st     <= (cfg_len == '0) ? SQ_STAT : SQ_DATA;
                end
                SQ_DATA: if (hs_done) begin
                    if (cnt == CW'(len_q) - 1'b1) st <= SQ_STAT;
                    else cnt <= cnt + 1'b1;
                end
                SQ_STAT: if (hs_done) st <= SQ_MSG;
                SQ_MSG:  if (hs_done) st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (st != SQ_IDLE);
        in_cmd     = (st == SQ_CMD);
        hs_start   = 1'b0;
        hs_to_host = 1'b0;
        hs_byte    = '0;
        tx_ready   = 1'b0;
        cfg_ready  = (st == SQ_SETUP);
        phase      = '{to_host: 1'b0, is_data: 1'b1, is_msg: 1'b0};
        case (st)
            SQ_CMD: begin
                phase    = '{to_host: 1'b0, is_data: 1'b0, is_msg: 1'b0};
                hs_start = hs_idle && !rx_pend;
            end
            SQ_DATA: begin
                phase = '{to_host: dir_q, is_data: 1'b1, is_msg: 1'b0};
                if (dir_q) begin
                    hs_start   = hs_idle && tx_valid;
                    tx_ready   = hs_idle && tx_valid;
                    hs_to_host = 1'b1;
                    hs_byte    = tx_data;
                end else begin
                    hs_start = hs_idle && !rx_pend;
                end
            end
            SQ_STAT: begin
                phase      = '{to_host: 1'b1, is_data: 1'b0, is_msg: 1'b0};
                hs_start   = hs_idle;
                hs_to_host = 1'b1;
                hs_byte    = stat_q;
            end
            SQ_MSG: begin
                phase      = '{to_host: 1'b1, is_data: 1'b0, is_msg: 1'b1};
                hs_start   = hs_idle;
                hs_to_host = 1'b1;
                hs_byte    = msg_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pbus_target.sv
module pbus_target
    import pbus_pkg::*;
#(
    parameter int UNIT_ID   = 2,
    parameter int CMD_BYTES = 6,
    parameter int LEN_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_rst_n,
    input  logic             bus_sel_n,
    input  logic             bus_ack_n,
    input  logic [7:0]       bus_db_in_n,
    output logic             bus_bsy_n,
    output logic             bus_req_n,
    output logic             bus_io_n,
    output logic             bus_cd_n,
    output logic             bus_msg_n,
    output logic [7:0]       bus_db_out_n,
    output logic             bus_db_oe,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_is_cmd,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [7:0]       tx_data,
    input  logic             cfg_valid,
    output logic             cfg_ready,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_to_host,
    input  logic [7:0]       cfg_status,
    input  logic [7:0]       cfg_msg
);
    logic             abort;
    logic             sel_hit_raw;
    logic             sel_hit;
    logic             busy;
    phase_t           phase;
    logic             in_cmd;
    logic             hs_start;
    logic             hs_to_host;
    logic [BUS_W-1:0] hs_byte;
    logic             hs_idle;
    logic             hs_req;
    logic             hs_oe;
    logic [BUS_W-1:0] hs_out;
    logic             hs_cap;
    logic             hs_done;

    assign abort   = !bus_rst_n;
    assign sel_hit = sel_hit_raw && !busy;

    pbus_sel_det #(.UNIT_ID(UNIT_ID)) i_sel (
        .sel_n (bus_sel_n),
        .db_n  (bus_db_in_n),
        .hit   (sel_hit_raw)
    );

    pbus_phase_seq #(.CMD_BYTES(CMD_BYTES), .LEN_W(LEN_W)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .abort      (abort),
        .sel_hit    (sel_hit),
        .sel_n      (bus_sel_n),
        .hs_idle    (hs_idle),
        .hs_done    (hs_done),
        .rx_pend    (rx_valid),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .cfg_valid  (cfg_valid),
        .cfg_len    (cfg_len),
        .cfg_to_host(cfg_to_host),
        .cfg_status (cfg_status),
        .cfg_msg    (cfg_msg),
        .busy       (busy),
        .phase      (phase),
        .in_cmd     (in_cmd),
        .hs_start   (hs_start),
        .hs_to_host (hs_to_host),
        .hs_byte    (hs_byte),
        .tx_ready   (tx_ready),
        .cfg_ready  (cfg_ready)
    );

    pbus_byte_hs i_hs (
        .clk     (clk),
        .rst     (rst),
        .abort   (abort),
        .start   (hs_start),
        .to_host (hs_to_host),
        .byte_in (hs_byte),
        .ack_n   (bus_ack_n),
        .idle    (hs_idle),
        .req     (hs_req),
        .oe      (hs_oe),
        .byte_out(hs_out),
        .cap     (hs_cap),
        .done    (hs_done)
    );

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            rx_valid  <= 1'b0;
            rx_data   <= '0;
            rx_is_cmd <= 1'b0;
        end else if (hs_cap) begin
            rx_valid  <= 1'b1;
            rx_data   <= ~bus_db_in_n;
            rx_is_cmd <= in_cmd;
        end else if (rx_ready) begin
            rx_valid  <= 1'b0;
        end
    end

    always_comb begin
        bus_bsy_n    = !busy;
        bus_req_n    = !hs_req;
        bus_io_n     = !phase.to_host;
        bus_cd_n     = phase.is_data;
        bus_msg_n    = !phase.is_msg;
        bus_db_oe    = hs_oe;
        bus_db_out_n = hs_oe ? ~hs_out : '1;
    end
endmodule

// File: rtl/pbus_target_chk.sv
module pbus_target_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_rst_n,
    input logic       bus_sel_n,
    input logic       bus_ack_n,
    input logic       bus_bsy_n,
    input logic       bus_req_n,
    input logic       bus_io_n,
    input logic       bus_cd_n,
    input logic       bus_msg_n,
    input logic [7:0] bus_db_out_n,
    input logic       bus_db_oe,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data
);
    // R1: without busy, no request, message or data drive
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        bus_bsy_n |-> (bus_req_n && bus_msg_n && !bus_db_oe));

    // R3: no request while the host still holds select
    assert_no_req_in_sel_R3: assert property (@(posedge clk) disable iff (rst)
        !bus_sel_n |-> bus_req_n);

    // R4: phase lines stable while a request is pending
    assert_phase_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!bus_req_n && $past(!bus_req_n)) |-> $stable({bus_io_n, bus_cd_n, bus_msg_n}));

    // R5: request begins only after ack was released
    assert_req_after_ack_rel_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req_n) |-> $past(bus_ack_n));

    // R5: request drops after ack is seen
    assert_req_drop_R5: assert property (@(posedge clk) disable iff (rst || !bus_rst_n)
        (!bus_req_n && !bus_ack_n) |=> bus_req_n);

    // R6: outgoing data driven and held through request
    assert_out_driven_R6: assert property (@(posedge clk) disable iff (rst)
        (!bus_req_n && !bus_io_n) |-> bus_db_oe);

    assert_out_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (!bus_req_n && $past(!bus_req_n)) |-> $stable(bus_db_out_n));

    // R8: message phase forces target-to-host command lines
    assert_msg_dir_R8: assert property (@(posedge clk) disable iff (rst)
        (!bus_msg_n && !bus_req_n) |-> (!bus_io_n && !bus_cd_n));

    // R9: host reset releases the bus
    assert_bus_reset_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_rst_n |=> (bus_bsy_n && bus_req_n && !bus_db_oe));

    // R10: received byte held until taken
    assert_rx_hold_R10: assert property (@(posedge clk) disable iff (rst || !bus_rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind pbus_target pbus_target_chk i_chk (.*);

// File: tb/test_pbus_target.sv
module test_pbus_target;
    localparam int UNIT_ID   = 2;
    localparam int CMD_BYTES = 6;
    localparam int LEN_W     = 8;

    typedef struct packed {
        logic [7:0] len;
        logic       to_host;
        logic [7:0] stat;
        logic [7:0] msg;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{len: 8'd4, to_host: 1'b1, stat: 8'h00, msg: 8'h00, seed: 8'h10},
        '{len: 8'd3, to_host: 1'b0, stat: 8'h02, msg: 8'h00, seed: 8'h40},
        '{len: 8'd0, to_host: 1'b1, stat: 8'h08, msg: 8'h80, seed: 8'h70},
        '{len: 8'd7, to_host: 1'b0, stat: 8'hFF, msg: 8'h0A, seed: 8'hA5}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_rst_n = 1'b1;
    logic       bus_sel_n = 1'b1;
    logic       bus_ack_n = 1'b1;
    logic [7:0] bus_db_in_n = 8'hFF;
    logic       bus_bsy_n, bus_req_n, bus_io_n, bus_cd_n, bus_msg_n, bus_db_oe;
    logic [7:0] bus_db_out_n;
    logic       rx_valid, rx_is_cmd, tx_ready, cfg_ready;
    logic       rx_ready = 1'b1;
    logic [7:0] rx_data;
    logic       tx_valid = 1'b1;
    logic [7:0] tx_data;
    logic       cfg_valid = 1'b1;
    logic [LEN_W-1:0] cfg_len = '0;
    logic       cfg_to_host = 1'b0;
    logic [7:0] cfg_status = 8'h00;
    logic [7:0] cfg_msg = 8'h00;

    int nchecks = 0;
    int nerrors = 0;
    bit finished = 1'b0;

    int         rxq_n = 0;
    logic [7:0] rxq_d [256];
    logic       rxq_c [256];
    int         tx_idx = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    assign tx_data = pat(tx_idx);

    pbus_target #(.UNIT_ID(UNIT_ID), .CMD_BYTES(CMD_BYTES), .LEN_W(LEN_W)) i_pbus_target (
        .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n), .bus_sel_n(bus_sel_n),
        .bus_ack_n(bus_ack_n), .bus_db_in_n(bus_db_in_n), .bus_bsy_n(bus_bsy_n),
        .bus_req_n(bus_req_n), .bus_io_n(bus_io_n), .bus_cd_n(bus_cd_n),
        .bus_msg_n(bus_msg_n), .bus_db_out_n(bus_db_out_n), .bus_db_oe(bus_db_oe),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_is_cmd(rx_is_cmd), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
        .cfg_len(cfg_len), .cfg_to_host(cfg_to_host), .cfg_status(cfg_status),
        .cfg_msg(cfg_msg)
    );

    always @(posedge clk) begin
        if (rx_valid && rx_ready) begin
            rxq_d[rxq_n % 256] <= rx_data;
            rxq_c[rxq_n % 256] <= rx_is_cmd;
            rxq_n <= rxq_n + 1;
        end
        if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nerrors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic wait_req(output bit got);
        got = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!bus_req_n) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic wait_req_high();
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (bus_req_n) break;
        end
    endtask

    task automatic idle_lines(input string rq);
        chk(bus_bsy_n && bus_req_n && bus_io_n && bus_cd_n && bus_msg_n && !bus_db_oe,
            rq, "bus outputs released",
            {bus_bsy_n, bus_req_n, bus_io_n, bus_cd_n, bus_msg_n, bus_db_oe}, 6'b111110);
    endtask

    task automatic host_send(input logic [7:0] b, input logic ioe, cde, msge,
                             input string rq);
        bit got;
        wait_req(got);
        chk(got, rq, "request for host byte", got, 1);
        chk({bus_io_n, bus_cd_n, bus_msg_n} == {ioe, cde, msge}, rq,
            "phase lines (io,cd,msg)", {bus_io_n, bus_cd_n, bus_msg_n}, {ioe, cde, msge});
        bus_db_in_n = ~b;
        bus_ack_n   = 1'b0;
        wait_req_high();
        @(negedge clk);
        chk(bus_req_n, "R5", "req stays released while ack low", bus_req_n, 1);
        bus_ack_n   = 1'b1;
        bus_db_in_n = 8'hFF;
    endtask

    task automatic host_recv(output logic [7:0] b, input logic ioe, cde, msge,
                             input string rq);
        bit got;
        logic [7:0] first;
        wait_req(got);
        chk(got, rq, "request for target byte", got, 1);
        chk({bus_io_n, bus_cd_n, bus_msg_n} == {ioe, cde, msge}, rq,
            "phase lines (io,cd,msg)", {bus_io_n, bus_cd_n, bus_msg_n}, {ioe, cde, msge});
        chk(bus_db_oe, "R6", "data driven under request", bus_db_oe, 1);
        first = ~bus_db_out_n;
        @(negedge clk);
        chk(!bus_req_n && (~bus_db_out_n == first), "R6", "data held under request",
            ~bus_db_out_n, first);
        b = first;
        bus_ack_n = 1'b0;
        wait_req_high();
        bus_ack_n = 1'b1;
    endtask

    task automatic select_unit(input logic [7:0] lines, input bit expect_hit);
        @(negedge clk);
        bus_sel_n   = 1'b0;
        bus_db_in_n = ~lines;
        @(negedge clk);
        chk(bus_bsy_n == !expect_hit, "R2", "busy after select", bus_bsy_n, !expect_hit);
        repeat (3) @(negedge clk);
        chk(bus_req_n, "R3", "no request while select held", bus_req_n, 1);
        bus_sel_n   = 1'b1;
        bus_db_in_n = 8'hFF;
    endtask

    task automatic run_txn(input vec_t v);
        int rx_base;
        int tx_base;
        logic [7:0] b;
        rx_base     = rxq_n;
        cfg_len     = v.len;
        cfg_to_host = v.to_host;
        cfg_status  = v.stat;
        cfg_msg     = v.msg;
        select_unit(8'h1 << UNIT_ID, 1'b1);
        for (int i = 0; i < CMD_BYTES; i++)
            host_send(v.seed + 8'(i), 1'b1, 1'b0, 1'b1, "R4");
        tx_base = tx_idx;
        for (int i = 0; i < int'(v.len); i++) begin
            if (v.to_host) begin
                host_recv(b, 1'b0, 1'b1, 1'b1, "R7");
                chk(b == pat(tx_base + i), "R7", "data byte to host", b, pat(tx_base + i));
            end else begin
                host_send(v.seed ^ 8'(i * 3 + 1), 1'b1, 1'b1, 1'b1, "R7");
            end
        end
        host_recv(b, 1'b0, 1'b0, 1'b1, "R8");
        chk(b == v.stat, "R8", "status byte", b, v.stat);
        host_recv(b, 1'b0, 1'b0, 1'b0, "R8");
        chk(b == v.msg, "R8", "message byte", b, v.msg);
        repeat (3) @(negedge clk);
        chk(bus_bsy_n, "R8", "busy released after message", bus_bsy_n, 1);
        for (int i = 0; i < CMD_BYTES; i++) begin
            chk(rxq_d[(rx_base + i) % 256] == v.seed + 8'(i) && rxq_c[(rx_base + i) % 256],
                "R4", "command byte on rx", rxq_d[(rx_base + i) % 256], v.seed + 8'(i));
        end
        if (!v.to_host) begin
            for (int i = 0; i < int'(v.len); i++) begin
                chk(rxq_d[(rx_base + CMD_BYTES + i) % 256] == (v.seed ^ 8'(i * 3 + 1)) &&
                    !rxq_c[(rx_base + CMD_BYTES + i) % 256], "R7", "data byte on rx",
                    rxq_d[(rx_base + CMD_BYTES + i) % 256], v.seed ^ 8'(i * 3 + 1));
            end
        end
        chk(rxq_n - rx_base == CMD_BYTES + (v.to_host ? 0 : int'(v.len)), "R7",
            "received byte count", rxq_n - rx_base,
            CMD_BYTES + (v.to_host ? 0 : int'(v.len)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchecks++;
            nerrors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    end

    initial begin
        bit got;
        vec_t v;
        repeat (3) @(negedge clk);
        idle_lines("R1");
        chk(!rx_valid, "R1", "rx_valid in reset", rx_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        idle_lines("R1");

        for (int k = 0; k < 4; k++) run_txn(VECS[k]);

        // R2: selection patterns that must be ignored
        select_unit(8'h1 << (UNIT_ID + 1), 1'b0);
        select_unit((8'h1 << UNIT_ID) | 8'h01, 1'b0);
        select_unit(8'h00, 1'b0);
        @(negedge clk);
        chk(bus_bsy_n, "R2", "still idle after foreign select", bus_bsy_n, 1);

        // R10: receive sink stalls
        rx_ready = 1'b0;
        select_unit(8'h1 << UNIT_ID, 1'b1);
        host_send(8'h5C, 1'b1, 1'b0, 1'b1, "R4");
        repeat (6) @(negedge clk);
        chk(bus_req_n, "R10", "no request while byte pending", bus_req_n, 1);
        chk(rx_valid && rx_data == 8'h5C, "R10", "pending byte held", rx_data, 8'h5C);
        rx_ready = 1'b1;
        for (int i = 1; i < 3; i++) host_send(8'h5C + 8'(i), 1'b1, 1'b0, 1'b1, "R10");

        // R9: host reset in the middle of the command phase
        wait_req(got);
        chk(got && !bus_bsy_n, "R9", "mid-command request pending", got, 1);
        bus_rst_n = 1'b0;
        @(negedge clk);
        bus_rst_n = 1'b1;
        idle_lines("R9");
        chk(!rx_valid, "R9", "rx cleared by bus reset", rx_valid, 0);
        v = '{len: 8'd2, to_host: 1'b1, stat: 8'h33, msg: 8'h00, seed: 8'hC0};
        run_txn(v);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end
endmodule